// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries a processor core through the state changes needed to accept an external interrupt. When `irq_take` is pulsed, the block samples the core state it needs: the vector number, the status word, the enable and user bits, both stack pointers, the current PC and the vector-table base. It first checks the interrupt-enable bit. If the bit is clear, the block reports at once that nothing was delivered.

If the interrupt is enabled, the block drives a single register write port, one write per cycle, in a fixed order:

1. It clears the user-mode bit.
2. It pushes the mode stack by shifting the status word.
3. If the core was in user mode, it saves the user stack pointer and loads the kernel stack pointer.
4. It records the return PC and the exception status, and clears the exception data address.

It then fetches the handler address from the vector table through a request/acknowledge read port that tolerates wait states, and loads it into the PC. If the read is refused, no PC write takes place and an error is reported. Each interrupt attempt ends with a one-cycle `done` pulse. Two result flags, `delivered` and `fault`, are valid during that pulse.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is held and after it is released, `done`, `rf_we` and `mem_req` are low until `irq_take` is seen.
- R2: If the sampled enable bit is 0, the block makes no register write and no memory request. It pulses `done` with `delivered`=0 and `fault`=0.
- R3: The write codes are 0 user-mode bit, 1 status word, 2 user stack pointer, 3 stack pointer, 4 return PC, 5 exception status, 6 exception data address, 7 PC. The first write of an enabled interrupt is code 0 with data 0, ahead of every other write.
- R4: The second write is code 1 with data ((old << 10) & 0x3FFFFFFF) | (old & 0x80000000).
- R5: If the sampled user bit is 1, code 2 (data = sampled stack pointer) and then code 3 (data = sampled kernel stack pointer) follow code 1. If the user bit is 0, neither code is written.
- R6: Next come code 4 with the sampled PC, code 5 with vec*256, and code 6 with 0, in that order.
- R7: After those writes, `mem_req` rises with `mem_addr` = base + vec*4. Both stay steady until a cycle in which `mem_ack` is high.
- R8: Read data lane i (bits 8i+7:8i) carries the byte at address mem_addr+i, so the word is little-endian. The cycle after an acknowledge without `mem_err`, the block writes code 7 with exactly that word.
- R9: An acknowledge with `mem_err` high causes no code 7 write. The block then pulses `done` with `fault`=1 and `delivered`=0.
- R10: `done` is high for exactly one cycle per accepted interrupt. After a completed PC load, `delivered`=1 and `fault`=0 during that pulse.
- R11: `irq_take` is ignored while a sequence is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_take | input | 1 | Starts a sequence when the block is idle |
| irq_vec | input | VEC_W | Interrupt vector number |
| st_ccs | input | 32 | Current status word |
| st_ie | input | 1 | Interrupt-enable bit |
| st_user | input | 1 | Core is in user mode |
| st_sp | input | 32 | Current stack pointer |
| st_ksp | input | 32 | Saved kernel stack pointer |
| st_pc | input | 32 | PC to return to |
| st_vbase | input | 32 | Vector table base address |
| rf_we | output | 1 | Register write strobe |
| rf_sel | output | 3 | Register write code (see R3) |
| rf_wdata | output | 32 | Register write data |
| mem_req | output | 1 | Vector read request |
| mem_addr | output | 32 | Vector read address |
| mem_ack | input | 1 | Read acknowledge |
| mem_err | input | 1 | Read refused (address unmapped), valid with acknowledge |
| mem_rdata | input | 32 | Read data, little-endian byte lanes |
| done | output | 1 | One-cycle completion pulse |
| delivered | output | 1 | Interrupt fully delivered, valid with done |
| fault | output | 1 | Vector read failed, valid with done |

## Verification
The hardest states to reach from the ports are the late ones: a refused vector read after all the state-saving writes have already gone out, and a second `irq_take` arriving partway through the write burst. The bench's memory model takes a per-vector wait count and error flag from the stimulus table. This lets it acknowledge after several wait cycles or refuse the read outright. A directed test pulses `irq_take` again, with a different vector, while writes are still being issued. The logged write stream and the count of `done` pulses must match a single sequence.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_take,
  input  logic [VEC_W-1:0] irq_vec,
  input  logic [31:0]      st_ccs,
  input  logic             st_ie,
  input  logic             st_user,
  input  logic [31:0]      st_sp,
  input  logic [31:0]      st_ksp,
  input  logic [31:0]      st_pc,
  input  logic [31:0]      st_vbase,
  output logic             rf_we,
  output logic [2:0]       rf_sel,
  output logic [31:0]      rf_wdata,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [31:0]      mem_rdata,
  output logic             done,
  output logic             delivered,
  output logic             fault
);
  localparam logic [2:0] W_MODE = 3'd0, W_CCS = 3'd1, W_USP = 3'd2, W_SP = 3'd3,
                         W_ERP = 3'd4, W_EXS = 3'd5, W_EDA = 3'd6, W_PC = 3'd7;
  localparam logic [31:0] KEEP_MASK = 32'h3FFF_FFFF;
  localparam logic [31:0] TOP_MASK  = 32'h8000_0000;

  typedef enum logic [2:0] {S_IDLE, S_CHECK, S_SAVE, S_FETCH, S_LOAD, S_DONE} st_t;

  st_t              st;
  logic [2:0]       step;
  logic [VEC_W-1:0] vec_q;
  logic [31:0]      ccs_q, sp_q, ksp_q, pc_q, base_q, word_q;
  logic             ie_q, user_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      step      <= W_MODE;
      vec_q     <= '0;
      ccs_q     <= '0;
      sp_q      <= '0;
      ksp_q     <= '0;
      pc_q      <= '0;
      base_q    <= '0;
      word_q    <= '0;
      ie_q      <= 1'b0;
      user_q    <= 1'b0;
      delivered <= 1'b0;
      fault     <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (irq_take) begin
          vec_q     <= irq_vec;
          ccs_q     <= st_ccs;
          sp_q      <= st_sp;
          ksp_q     <= st_ksp;
          pc_q      <= st_pc;
          base_q    <= st_vbase;
          ie_q      <= st_ie;
          user_q    <= st_user;
          delivered <= 1'b0;
          fault     <= 1'b0;
          st        <= S_CHECK;
        end
        S_CHECK: begin
          step <= W_MODE;
          st   <= ie_q ? S_SAVE : S_DONE;
        end
        S_SAVE: begin
          if (step == W_EDA)                st   <= S_FETCH;
          else if (step == W_CCS && !user_q) step <= W_ERP;
          else                               step <= step + 3'd1;
        end
        S_FETCH: if (mem_ack) begin
          if (mem_err) begin
            fault <= 1'b1;
            st    <= S_DONE;
          end else begin
            word_q <= mem_rdata;
            st     <= S_LOAD;
          end
        end
        S_LOAD: begin
          delivered <= 1'b1;
          st        <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [31:0] pushed_ccs;
  assign pushed_ccs = ((ccs_q << 10) & KEEP_MASK) | (ccs_q & TOP_MASK);

  assign rf_we  = (st == S_SAVE) || (st == S_LOAD);
  assign rf_sel = (st == S_LOAD) ? W_PC : step;

  always_comb begin
    unique case (rf_sel)
      W_MODE:  rf_wdata = 32'd0;
      W_CCS:   rf_wdata = pushed_ccs;
      W_USP:   rf_wdata = sp_q;
      W_SP:    rf_wdata = ksp_q;
      W_ERP:   rf_wdata = pc_q;
      W_EXS:   rf_wdata = 32'(vec_q) << 8;
      W_EDA:   rf_wdata = 32'd0;
      default: rf_wdata = word_q;
    endcase
  end

  assign mem_req  = (st == S_FETCH);
  assign mem_addr = base_q + (32'(vec_q) << 2);
  assign done     = (st == S_DONE);
endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rf_we,
  input logic [2:0]  rf_sel,
  input logic [31:0] rf_wdata,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic        mem_err,
  input logic [31:0] mem_rdata,
  input logic        done
);
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  assert_ccs_after_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && rf_sel == 3'd1 |-> $past(rf_we) && $past(rf_sel) == 3'd0 && $past(rf_wdata) == 32'd0);

  assert_sp_after_usp_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && rf_sel == 3'd3 |-> $past(rf_we) && $past(rf_sel) == 3'd2);

  assert_pc_from_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && rf_sel == 3'd7 |-> $past(mem_req && mem_ack && !mem_err) && rf_wdata == $past(mem_rdata));

  assert_no_pc_on_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_err |=> !rf_we && done);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && mem_req));
endmodule

bind irq_entry_seq irq_entry_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rf_we(rf_we), .rf_sel(rf_sel), .rf_wdata(rf_wdata),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
  .mem_rdata(mem_rdata), .done(done)
);

// File: tb/irq_entry_seq_tb_top.sv
`timescale 1ns/1ps
module irq_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_take = 1'b0;
  logic [7:0]  irq_vec = '0;
  logic [31:0] st_ccs = '0, st_sp = '0, st_ksp = '0, st_pc = '0, st_vbase = '0;
  logic        st_ie = 1'b0, st_user = 1'b0;
  logic        rf_we, mem_req, done, delivered, fault;
  logic [2:0]  rf_sel;
  logic [31:0] rf_wdata, mem_addr;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata;

  always #2 clk = ~clk;

  irq_entry_seq #(.VEC_W(8)) dut_i (.*);

  typedef struct packed {
    logic        ie;
    logic        user;
    logic [7:0]  vec;
    logic [31:0] ccs;
    logic [31:0] sp;
    logic [31:0] ksp;
    logic [31:0] pc;
    logic [31:0] base;
    logic [3:0]  wt;
    logic        er;
  } tc_t;

  localparam tc_t TBL [6] = '{
    '{1'b1, 1'b1, 8'd5,   32'hFFFF_FFFF, 32'h0000_7F00, 32'h0000_9000, 32'h0000_1234, 32'h0000_0400, 4'd0, 1'b0},
    '{1'b1, 1'b0, 8'd0,   32'h1234_5678, 32'h0000_2000, 32'h0000_3000, 32'h4000_0010, 32'h0001_0000, 4'd3, 1'b0},
    '{1'b0, 1'b1, 8'd9,   32'hABCD_EF01, 32'h0000_2222, 32'h0000_3333, 32'h0000_4444, 32'h0000_0800, 4'd0, 1'b0},
    '{1'b1, 1'b1, 8'd255, 32'h8000_0001, 32'h1111_0000, 32'h2222_0000, 32'h3333_0000, 32'h0000_1000, 4'd2, 1'b1},
    '{1'b1, 1'b0, 8'd128, 32'h7FFF_FFFF, 32'h0000_0004, 32'h0000_0008, 32'h0000_000C, 32'hFFFF_FC00, 4'd1, 1'b0},
    '{1'b1, 1'b1, 8'h3C,  32'h0000_03FF, 32'hDEAD_0000, 32'hBEEF_0000, 32'hCAFE_0002, 32'h0000_0000, 4'd5, 1'b0}
  };

  int total = 0, bad = 0, cyc = 0;
  logic [3:0] cur_wt = '0;
  logic       cur_er = 1'b0;
  int         wcnt = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[7:0] ^ 8'h5A, a[15:8], 8'hC3, a[31:24] + 8'h11};
  endfunction

  assign mem_rdata = mem_word(mem_addr);

  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt >= int'(cur_wt)) begin mem_ack <= 1'b1; mem_err <= cur_er; end
      else begin mem_ack <= 1'b0; mem_err <= 1'b0; wcnt <= wcnt + 1; end
    end else begin
      mem_ack <= 1'b0; mem_err <= 1'b0; wcnt <= 0;
    end
  end

  logic [2:0]  lg_sel [16];
  logic [31:0] lg_dat [16];
  int lg_n = 0, done_n = 0, req_n = 0;
  logic [31:0] req_addr = '0;
  logic d_deliv = 1'b0, d_fault = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && rf_we && lg_n < 16) begin
      lg_sel[lg_n] <= rf_sel; lg_dat[lg_n] <= rf_wdata; lg_n <= lg_n + 1;
    end
    if (rst_n && done) begin done_n <= done_n + 1; d_deliv <= delivered; d_fault <= fault; end
    if (rst_n && mem_req) begin req_n <= req_n + 1; req_addr <= mem_addr; end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic run_case(input tc_t t, input logic poke);
    logic [2:0]  es [16];
    logic [31:0] ed [16];
    int n = 0;
    logic [31:0] addr;
    @(negedge clk);
    lg_n = 0; done_n = 0; req_n = 0;
    cur_wt = t.wt; cur_er = t.er;
    irq_vec = t.vec; st_ccs = t.ccs; st_ie = t.ie; st_user = t.user;
    st_sp = t.sp; st_ksp = t.ksp; st_pc = t.pc; st_vbase = t.base;
    irq_take = 1'b1;
    @(negedge clk);
    irq_take = 1'b0;
    irq_vec = t.vec + 8'd1; st_pc = ~t.pc; st_ccs = ~t.ccs;
    if (poke) begin
      @(negedge clk); @(negedge clk);
      irq_take = 1'b1;
      @(negedge clk);
      irq_take = 1'b0;
    end
    for (int i = 0; i < 60 && done_n == 0; i++) @(negedge clk);
    for (int i = 0; i < 4; i++) @(negedge clk);
    addr = t.base + (32'(t.vec) << 2);
    if (t.ie) begin
      es[n] = 3'd0; ed[n] = 32'd0; n++;
      es[n] = 3'd1; ed[n] = ((t.ccs << 10) & 32'h3FFF_FFFF) | (t.ccs & 32'h8000_0000); n++;
      if (t.user) begin
        es[n] = 3'd2; ed[n] = t.sp; n++;
        es[n] = 3'd3; ed[n] = t.ksp; n++;
      end
      es[n] = 3'd4; ed[n] = t.pc; n++;
      es[n] = 3'd5; ed[n] = 32'(t.vec) * 256; n++;
      es[n] = 3'd6; ed[n] = 32'd0; n++;
      if (!t.er) begin es[n] = 3'd7; ed[n] = mem_word(addr); n++; end
    end
    chk(lg_n == n, t.ie ? (t.user ? "R5" : "R5") : "R2", "write count", 32'(lg_n), 32'(n));
    for (int i = 0; i < n && i < lg_n; i++) begin
      chk(lg_sel[i] == es[i], i == 0 ? "R3" : (es[i] == 3'd7 ? "R8" : "R6"), "write code",
          32'(lg_sel[i]), 32'(es[i]));
      chk(lg_dat[i] == ed[i], es[i] == 3'd1 ? "R4" : (es[i] == 3'd7 ? "R8" : "R6"), "write data",
          lg_dat[i], ed[i]);
    end
    chk(done_n == 1, poke ? "R11" : "R10", "done pulses", 32'(done_n), 32'd1);
    if (t.ie) begin
      chk(req_n == int'(t.wt) + 1, "R7", "request cycles", 32'(req_n), 32'(t.wt) + 1);
      chk(req_addr == addr, "R7", "vector address", req_addr, addr);
      chk(d_fault == t.er, "R9", "fault flag", 32'(d_fault), 32'(t.er));
      chk(d_deliv == !t.er, "R10", "delivered flag", 32'(d_deliv), 32'(!t.er));
    end else begin
      chk(req_n == 0, "R2", "request cycles", 32'(req_n), 32'd0);
      chk(d_deliv == 1'b0 && d_fault == 1'b0, "R2", "flags", {30'd0, d_deliv, d_fault}, 32'd0);
    end
  endtask

  initial begin
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!done && !rf_we && !mem_req, "R1", "outputs in reset", {29'd0, done, rf_we, mem_req}, 32'd0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!done && !rf_we && !mem_req, "R1", "outputs idle", {29'd0, done, rf_we, mem_req}, 32'd0);
    end
    for (int k = 0; k < 6; k++) run_case(TBL[k], 1'b0);
    run_case(TBL[0], 1'b1);
    run_case(TBL[3], 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    bad++; total++;
    $display("FAIL watchdog act=%0d exp=<20000", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule